// File: doc/BRIEF.md
# Chained-Transfer SPI Master

This block is a SPI master driven by a processor through plain configuration pins and a single data-word stream. The configuration selects one chip-select line, the active level of each line, the clock idle level and sampling phase, the bit order, half-duplex operation, the frame length and the serial clock rate. A data word offered on the write stream starts one transfer of 1 to 32 bits. Bits received during the transfer collect in a read word that software can read at any time.

An end flag, captured with each word, controls chip select when the transfer finishes. If the flag is set, chip select is released. If it is clear, chip select stays asserted so that the next word continues the same transaction. A transaction can therefore be a command segment followed by a reply segment, and half-duplex can be turned on between those segments. An offline control holds the bus quiet.

The write stream follows valid/ready rules. A word is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is the writable status. It is low while a transfer runs and while the bus is offline. A word offered while `wr_ready` is low is not taken, and the source may keep it offered until ready rises. All configuration pins are sampled at the clock edge that takes a word and are held for the whole transfer.

Top module: `spi_chain_master`

## Requirements
- R1: After reset `idle` and `wr_ready` are 1, every chip-select line is at its released level (the inverse of its polarity bit), and `spi_sck` equals `cfg_cpol`.
- R2: A length field of L gives a transfer of exactly L+1 bits. L = 0 gives one bit.
- R3: A divider field of D gives D+2 system clock cycles between successive `spi_sck` edges of a transfer (D = 14 gives a divide-by-16 half period).
- R4: With `cfg_lsb_first` = 0, the frame is left-aligned in `wr_data`. An N-bit frame sends bit 31 first, then bits 30 down to 32-N.
- R5: With `cfg_lsb_first` = 1, an N-bit left-aligned frame sends bit 32-N first, then the bits above it up to bit 31.
- R6: Each received bit shifts into `rd_data` at bit 0 and moves the earlier content up. After an N-bit transfer, the last N bits received occupy bits N-1..0, with the first bit received at bit N-1. The register is not cleared between transfers.
- R7: If the end flag of a transfer is 1, chip select is released when the transfer finishes and `idle` returns to 1. If it is 0, chip select stays asserted and `idle` stays 0, while `wr_ready` returns to 1 so that the next word continues the transaction.
- R8: During a transfer, the line picked by the one-hot `cfg_cs_sel` is driven to its polarity bit (1 means active high), and every other line stays at the inverse of its polarity bit.
- R9: While a transfer runs, `wr_ready` is 0 and a word offered on the write stream is dropped. It neither changes the running transfer nor starts a new one.
- R10: While `cfg_offline` is 1, `wr_ready` is 0 and no transfer starts, even if a word is offered in the same cycle. A chip select held from a chained transfer is released, and `idle` reads 1.
- R11: `cfg_cpol` sets the idle level of `spi_sck`. With phase 0, input is sampled on the first edge of each bit and output changes on the second edge. With phase 1, output changes on the first edge and input is sampled on the second.
- R12: In a half-duplex transfer `spi_mosi_oe` is 0 and input bits are taken from `spi_mosi_i` instead of `spi_miso`. Half-duplex may differ between the chained segments of one transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_offline | input | 1 | Hold the bus offline and refuse words |
| cfg_end | input | 1 | Release chip select after this transfer |
| cfg_cs_sel | input | NCS | One-hot chip-select choice |
| cfg_cs_pol | input | NCS | Per-line active level, 1 = active high |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | Send least significant frame bit first |
| cfg_half_duplex | input | 1 | Receive on the MOSI line |
| cfg_len_m1 | input | 5 | Frame length minus one |
| cfg_div_m2 | input | DIV_W | Half-period divisor minus two |
| wr_valid | input | 1 | Data word offered |
| wr_data | input | 32 | Left-aligned transmit word |
| wr_ready | output | 1 | Writable: a word will be taken |
| rd_data | output | 32 | Received bits |
| idle | output | 1 | No transfer and chip select released |
| spi_sck | output | 1 | Serial clock |
| spi_cs | output | NCS | Chip-select lines |
| spi_mosi_o | output | 1 | MOSI output value |
| spi_mosi_oe | output | 1 | MOSI output enable |
| spi_mosi_i | input | 1 | MOSI line input value, used in half-duplex |
| spi_miso | input | 1 | MISO input |

## Verification
Two events can fall in the same cycle: a word offered on the write stream, and the offline control being raised or a transfer still running. The bench offers a word in the exact cycle that `cfg_offline` rises while a chained chip select is still held. It also offers a word in the middle of a running transfer. In both cases it judges at the pins that nothing started: no further `spi_sck` edges, the captured bit count and the read word unchanged from the prediction, chip select released, and `idle` back to 1.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } eng_state_t;

  // Settings frozen for the duration of one transfer
  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             hd;
    logic             fin;
    logic [LEN_W-1:0] len;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_half_clk.sv
module spi_half_clk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] load_div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= load_div;
      cnt_q <= CNT_W'(load_div) + CNT_W'(1);
    end else if (tick) begin
      cnt_q <= CNT_W'(div_q) + CNT_W'(1);
    end else if (run) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // Half period is at least two cycles, so ticks never touch
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              lsb_first,
  input  logic [LEN_W-1:0]  len,
  input  logic [WORD_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              sample_bit,
  output logic              tx_bit,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] rev;
  logic [WORD_W-1:0] aligned;
  logic [LEN_W-1:0]  shamt;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;

  // Reverse the word so the lowest frame bit can leave from the top
  always_comb begin
    for (int i = 0; i < WORD_W; i++) rev[i] = load_data[WORD_W-1-i];
  end

  assign shamt   = LEN_W'(WORD_W - 1) - len;
  assign aligned = lsb_first ? (rev << shamt) : load_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load) tx_q <= aligned;
      else if (shift_en) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      if (sample_en) rx_q <= {rx_q[WORD_W-2:0], sample_bit};
    end
  end

  assign tx_bit  = tx_q[WORD_W-1];
  assign rx_word = rx_q;

  AST_RX_ENTERS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> rx_word[0] == $past(sample_bit)); // R6
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set,
  input  logic           clr,
  input  logic [NCS-1:0] sel_in,
  input  logic [NCS-1:0] pol,
  output logic           held,
  output logic [NCS-1:0] cs_o
);
  logic           held_q;
  logic [NCS-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      sel_q  <= '0;
    end else if (set) begin
      held_q <= 1'b1;
      sel_q  <= sel_in;
    end else if (clr) begin
      held_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_line
    assign cs_o[g] = (held_q && sel_q[g]) ? pol[g] : ~pol[g];
  end

  assign held = held_q;

  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> held); // R7
endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
  import spi_chain_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_offline,
  input  logic              cfg_end,
  input  logic [NCS-1:0]    cfg_cs_sel,
  input  logic [NCS-1:0]    cfg_cs_pol,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_half_duplex,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [DIV_W-1:0]  cfg_div_m2,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              idle,
  output logic              spi_sck,
  output logic [NCS-1:0]    spi_cs,
  output logic              spi_mosi_o,
  output logic              spi_mosi_oe,
  input  logic              spi_mosi_i,
  input  logic              spi_miso
);
  eng_state_t       state_q;
  xfer_cfg_t        xcfg_q;
  logic [LEN_W-1:0] bit_cnt_q;
  logic             lead_q;
  logic             sck_q;
  logic             tick;
  logic             accept;
  logic             cs_held;
  logic             cs_clr;
  logic             shift_en;
  logic             sample_en;
  logic             sample_bit;
  logic             running;

  assign running  = (state_q != ST_IDLE);
  assign wr_ready = (state_q == ST_IDLE) && !cfg_offline;
  assign accept   = wr_valid && wr_ready;

  spi_half_clk #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .run      (running),
    .load_div (cfg_div_m2),
    .tick     (tick)
  );

  // Edge roles: phase 0 samples on the leading edge, phase 1 on the trailing edge
  always_comb begin
    shift_en  = 1'b0;
    sample_en = 1'b0;
    if (state_q == ST_SHIFT && tick) begin
      if (lead_q) begin
        sample_en = !xcfg_q.cpha;
        shift_en  = xcfg_q.cpha && (bit_cnt_q != '0);
      end else begin
        sample_en = xcfg_q.cpha;
        shift_en  = !xcfg_q.cpha;
      end
    end
  end

  assign sample_bit = xcfg_q.hd ? spi_mosi_i : spi_miso;

  spi_bit_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .lsb_first  (cfg_lsb_first),
    .len        (cfg_len_m1),
    .load_data  (wr_data),
    .shift_en   (shift_en),
    .sample_en  (sample_en),
    .sample_bit (sample_bit),
    .tx_bit     (spi_mosi_o),
    .rx_word    (rd_data)
  );

  assign cs_clr = (state_q == ST_TAIL && tick && xcfg_q.fin) ||
                  (state_q == ST_IDLE && cfg_offline);

  spi_cs_ctrl #(.NCS(NCS)) u_cs (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (accept),
    .clr    (cs_clr),
    .sel_in (cfg_cs_sel),
    .pol    (cfg_cs_pol),
    .held   (cs_held),
    .cs_o   (spi_cs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      xcfg_q    <= '0;
      bit_cnt_q <= '0;
      lead_q    <= 1'b1;
      sck_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            xcfg_q    <= '{cpol: cfg_cpol, cpha: cfg_cpha, hd: cfg_half_duplex,
                           fin: cfg_end, len: cfg_len_m1};
            state_q   <= ST_SHIFT;
            bit_cnt_q <= '0;
            lead_q    <= 1'b1;
            sck_q     <= cfg_cpol;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck_q  <= ~sck_q;
            lead_q <= ~lead_q;
            if (!lead_q) begin
              if (bit_cnt_q == xcfg_q.len) state_q <= ST_TAIL;
              else bit_cnt_q <= bit_cnt_q + LEN_W'(1);
            end
          end
        end
        ST_TAIL: begin
          if (tick) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_sck     = (state_q == ST_IDLE) ? cfg_cpol : sck_q;
  assign spi_mosi_oe = ~xcfg_q.hd;
  assign idle        = (state_q == ST_IDLE) && !cs_held;

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> bit_cnt_q <= xcfg_q.len); // R2
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !wr_ready); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(xcfg_q)); // R9
  AST_OFFLINE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_offline && state_q == ST_IDLE) |=> state_q == ST_IDLE); // R10
  AST_SCK_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> spi_sck == xcfg_q.cpol); // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> spi_cs == ~cfg_cs_pol); // R8
endmodule

// File: tb/spi_chain_master_test.sv
module spi_chain_master_test;
  localparam int NCS = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_offline = 1'b0, cfg_end = 1'b1;
  logic [NCS-1:0] cfg_cs_sel = 4'b0001, cfg_cs_pol = 4'b0000;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_half_duplex = 1'b0;
  logic [4:0] cfg_len_m1 = 5'd7;
  logic [DW-1:0] cfg_div_m2 = 8'd0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic wr_ready, idle, spi_sck, spi_mosi_o, spi_mosi_oe;
  logic [31:0] rd_data;
  logic [NCS-1:0] spi_cs;
  logic spi_mosi_i = 1'b0, spi_miso = 1'b0;

  spi_chain_master #(.NCS(NCS), .DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_offline(cfg_offline), .cfg_end(cfg_end),
    .cfg_cs_sel(cfg_cs_sel), .cfg_cs_pol(cfg_cs_pol), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_half_duplex(cfg_half_duplex), .cfg_len_m1(cfg_len_m1),
    .cfg_div_m2(cfg_div_m2), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_data(rd_data), .idle(idle), .spi_sck(spi_sck),
    .spi_cs(spi_cs), .spi_mosi_o(spi_mosi_o), .spi_mosi_oe(spi_mosi_oe),
    .spi_mosi_i(spi_mosi_i), .spi_miso(spi_miso)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, edge_cnt = 0, last_tog = 0;
  bit mon_on = 1'b0, tog_seen = 1'b0;
  logic last_sck = 1'b0;
  bit m_cpol, m_cpha, m_hd;
  int exp_hp = 2, cap_n = 0, idx = 0, hp_bad = 0, cs_bad = 0, oe_bad = 0;
  logic [NCS-1:0] exp_cs;
  logic [31:0] cap = 32'h0, rsp_m = 32'h0, rsp_s = 32'h0, exp_rx = 32'h0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model of the slave: records MOSI and advances its reply on each sampling edge
  always @(negedge clk) begin
    cyc++;
    if (spi_sck !== last_sck) begin
      edge_cnt++;
      if (mon_on) begin
        if (tog_seen && (cyc - last_tog) != exp_hp) hp_bad++;
        tog_seen = 1'b1;
        last_tog = cyc;
        if ((m_cpha == 1'b0) ? (spi_sck != m_cpol) : (spi_sck == m_cpol)) begin
          if (cap_n < 32) cap[cap_n] = spi_mosi_o;
          cap_n++;
          if (spi_cs !== exp_cs) cs_bad++;
          if (spi_mosi_oe !== ~m_hd) oe_bad++;
          idx++;
          spi_miso   = (idx < 32) ? rsp_m[31-idx] : 1'b0;
          spi_mosi_i = (idx < 32) ? rsp_s[31-idx] : 1'b0;
        end
      end
      last_sck = spi_sck;
    end
  end

  function automatic logic [NCS-1:0] act_vec(input logic [NCS-1:0] sel, input logic [NCS-1:0] pol);
    return (sel & pol) | (~sel & ~pol);
  endfunction

  task automatic xfer(input logic [31:0] d, input int len, input int dv,
                      input bit cpol, input bit cpha, input bit lsb, input bit hd,
                      input bit fin, input int csi, input logic [NCS-1:0] pol,
                      input logic [31:0] rm, input logic [31:0] rs, input bit poke);
    int n;
    logic [31:0] exp_tx, mask;
    int e0;
    n = len + 1;
    mon_on = 1'b0;
    cfg_len_m1 = 5'(len); cfg_div_m2 = DW'(dv);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_half_duplex = hd;
    cfg_end = fin; cfg_cs_sel = NCS'(1) << csi; cfg_cs_pol = pol;
    repeat (2) @(negedge clk);
    m_cpol = cpol; m_cpha = cpha; m_hd = hd; exp_hp = dv + 2;
    exp_cs = act_vec(cfg_cs_sel, pol);
    cap = 32'h0; cap_n = 0; idx = 0; hp_bad = 0; cs_bad = 0; oe_bad = 0; tog_seen = 1'b0;
    rsp_m = rm; rsp_s = rs; spi_miso = rm[31]; spi_mosi_i = rs[31];
    mon_on = 1'b1;
    wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(wr_ready == 1'b0, "R9 ready low in transfer", 32'(wr_ready), 32'h0);
      wr_data = ~d; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
    end
    while (!wr_ready) @(negedge clk);
    mon_on = 1'b0;
    for (int i = 0; i < n; i++) exp_rx = {exp_rx[30:0], hd ? rs[31-i] : rm[31-i]};
    exp_tx = 32'h0;
    for (int i = 0; i < n; i++) exp_tx[i] = lsb ? d[32-n+i] : d[31-i];
    mask = (n == 32) ? 32'hffff_ffff : ((32'h1 << n) - 32'h1);
    chk(cap_n == n, "R2 bit count", 32'(cap_n), 32'(n));
    if (!hd) begin
      if (lsb) chk((cap & mask) == exp_tx, "R5 lsb-first order", cap & mask, exp_tx);
      else     chk((cap & mask) == exp_tx, "R4 msb-first order", cap & mask, exp_tx);
    end
    chk(rd_data == exp_rx, "R6 read word", rd_data, exp_rx);
    chk(hp_bad == 0, "R3 half period", 32'(hp_bad), 32'h0);
    chk(cs_bad == 0, "R8 active select", 32'(cs_bad), 32'h0);
    chk(oe_bad == 0, "R12 mosi direction", 32'(oe_bad), 32'h0);
    chk(spi_sck == cpol, "R11 sck idle level", 32'(spi_sck), 32'(cpol));
    chk(idle == fin, "R7 idle after transfer", 32'(idle), 32'(fin));
    chk(spi_cs == (fin ? ~pol : exp_cs), "R7 select after transfer", 32'(spi_cs),
        32'(fin ? ~pol : exp_cs));
    if (poke) begin
      e0 = edge_cnt;
      repeat (20) @(negedge clk);
      chk(edge_cnt == e0, "R9 dropped word starts nothing", 32'(edge_cnt), 32'(e0));
      chk(rd_data == exp_rx, "R9 read word unchanged", rd_data, exp_rx);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0;
    logic [31:0] d, r1, r2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(idle == 1'b1, "R1 idle", 32'(idle), 32'h1);
    chk(wr_ready == 1'b1, "R1 writable", 32'(wr_ready), 32'h1);
    chk(spi_cs == 4'b1111, "R1 select released", 32'(spi_cs), 32'hf);
    chk(spi_sck == 1'b0, "R1 sck idle", 32'(spi_sck), 32'h0);
    chk(rd_data == 32'h0, "R1 read word", rd_data, 32'h0);

    // R2 one-bit transfer
    xfer(32'h8000_0000, 0, 0, 0, 0, 0, 0, 1, 0, 4'b0000, 32'h8000_0000, 32'h0, 0);
    // R3/R4 24-bit frame with divide-by-16
    xfer(32'hA5C3_1E00, 23, 14, 0, 0, 0, 0, 1, 2, 4'b0100, 32'h3C5A_9900, 32'h0, 0);
    // R5 lsb-first 8-bit
    xfer(32'hB400_0000, 7, 1, 0, 0, 1, 0, 1, 1, 4'b0000, 32'h6D00_0000, 32'h0, 0);
    // R11 all four clock modes
    for (int m = 0; m < 4; m++)
      xfer(32'hC3A5_0000 ^ 32'(m << 24), 11, 2, m[1], m[0], 0, 0, 1, 3, 4'b1010,
           32'h5A3C_0000, 32'h0, 0);
    // R7/R12 chained command then half-duplex reply
    xfer(32'h8123_0000, 15, 1, 0, 0, 0, 0, 0, 1, 4'b0010, 32'hFFFF_0000, 32'h0, 0);
    chk(wr_ready == 1'b1, "R7 writable while chained", 32'(wr_ready), 32'h1);
    xfer(32'h0, 7, 1, 0, 0, 0, 1, 1, 1, 4'b0010, 32'h0000_0000, 32'h9600_0000, 0);
    // R9 word offered mid-transfer is dropped
    xfer(32'h1234_5678, 31, 0, 1, 0, 0, 0, 1, 0, 4'b0001, 32'hDEAD_BEEF, 32'h0, 1);
    // R10 offline raised in the same cycle a word is offered, with select held
    xfer(32'hF000_0000, 3, 0, 0, 1, 0, 0, 0, 2, 4'b0000, 32'hA000_0000, 32'h0, 0);
    chk(idle == 1'b0, "R7 held before offline", 32'(idle), 32'h0);
    cfg_offline = 1'b1; wr_data = 32'hFFFF_FFFF; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    e0 = edge_cnt;
    repeat (20) @(negedge clk);
    chk(wr_ready == 1'b0, "R10 not writable offline", 32'(wr_ready), 32'h0);
    chk(spi_cs == 4'b1111, "R10 select released", 32'(spi_cs), 32'hf);
    chk(idle == 1'b1, "R10 idle offline", 32'(idle), 32'h1);
    chk(edge_cnt == e0, "R10 no clock offline", 32'(edge_cnt), 32'(e0));
    chk(rd_data == exp_rx, "R10 read word unchanged", rd_data, exp_rx);
    cfg_offline = 1'b0;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R10 writable again", 32'(wr_ready), 32'h1);

    // Random transfers across modes, lengths and rates
    for (int k = 0; k < 30; k++) begin
      d = $urandom; r1 = $urandom; r2 = $urandom;
      xfer(d, int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
           1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
           1, int'($urandom_range(0, NCS-1)), 4'($urandom), r1, r2, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule